// File: doc/BRIEF.md
# Multicontext Lookup-Table Logic Cell

This block is one logic cell of a dynamically reconfigurable array. It keeps four complete configurations in a small local store. A context number, broadcast to every cell of the array, picks the configuration that is active in a given cycle. Each configuration holds three things: a 4-input truth table, the routing selects that choose which of eight candidate signals drive the four table inputs, and an enable bit for the output register.

The output register is the only way to carry a value from one context to a later one. A context whose register enable is clear leaves the stored value untouched, so a later context can still use it. Configuration words are written through a load port that has a write enable, a slot number and a full word. Any slot can be loaded while the cell keeps evaluating.

A parameter selects how the context is read. In the flat mode the chosen configuration is taken combinationally in the same cycle. In the staged mode the configuration word passes through a register, which removes the read from the logic path and adds one cycle of lag.

Top module: `mclut_cell`

## Requirements
- R1: While reset is asserted, and after its release until a slot is written, every slot holds the all-zero word. The staged configuration register is zero and `regQ` is 0. The all-zero word gives a constant-zero truth table, so `lutOut` is 0.
- R2: When `cfgWe` is high at a rising edge, `cfgWord` is stored into slot `cfgSlot`. The word layout is: bits [15:0] truth table; bits [18:16], [21:19], [24:22] and [27:25] the selects for table inputs 0 to 3; bit 28 the register enable.
- R3: `lutOut` equals truth-table bit `a`. Bit i of `a` is candidate `sel_i`. Candidate 0 is `regQ`, and candidate k (1 to 7) is `extIn[k-1]`.
- R4: With `PIPE_CTX` = 0, the configuration used in a cycle is the slot named by `ctxId` in that same cycle, including a word written into that slot at the previous edge.
- R5: With `PIPE_CTX` = 1, the configuration used in a cycle is the content, before that edge's write, of the slot that `ctxId` named at the previous rising edge.
- R6: At a rising edge, `regQ` loads `lutOut` when the active register enable is 1, and keeps its value when the enable is 0.
- R7: Writing a slot other than the one being read leaves `lutOut` and `regQ` exactly as they would have been without the write.
- R8: A value produced in one context and then held through contexts with the register enable clear is available as candidate 0 to any later context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ctxId | input | 2 | Broadcast context number |
| extIn | input | 7 | External candidate signals (neighbour outputs, primary inputs) |
| cfgWe | input | 1 | Configuration write enable |
| cfgSlot | input | 2 | Slot to write |
| cfgWord | input | 29 | Configuration word |
| lutOut | output | 1 | Combinational lookup-table result |
| regQ | output | 1 | Output register |

## Verification
The assertions assume that `ctxId`, `cfgSlot` and `cfgWe` are valid two-state values at every edge outside reset. They also assume that the context number seen before the first edge after reset release is irrelevant. The staged-read property is armed only after one full clock with reset released. The bench changes every input only at the falling edge and never leaves an input undriven. It releases reset at a falling edge, so every sampled context number and slot number is a defined value within the four slots.

// File: rtl/mclut_pkg.sv
package mclut_pkg;
  parameter int LUT_K  = 4;
  parameter int NCTX   = 4;
  parameter int NCAND  = 8;
  parameter int CTX_W  = $clog2(NCTX);
  parameter int SEL_W  = $clog2(NCAND);
  parameter int TT_W   = 1 << LUT_K;
  parameter int NEXT   = NCAND - 1;
  parameter int CFG_W  = TT_W + LUT_K * SEL_W + 1;

  // register enable on top, then the selects (input 0 lowest), then the truth table
  typedef struct packed {
    logic                        regEn;
    logic [LUT_K-1:0][SEL_W-1:0] sel;
    logic [TT_W-1:0]             truth;
  } cfg_t;

  typedef struct packed {
    logic [NCTX-1:0]  slotWr;
    logic [CTX_W-1:0] rdCtx;
  } strobe_t;
endpackage

// File: rtl/mclut_ctl.sv
module mclut_ctl
  import mclut_pkg::*;
(
  input  logic [CTX_W-1:0] ctxId,
  input  logic             cfgWe,
  input  logic [CTX_W-1:0] cfgSlot,
  output strobe_t          strb
);
  for (genvar s = 0; s < NCTX; s++) begin : g_dec
    assign strb.slotWr[s] = cfgWe && (cfgSlot == CTX_W'(s));
  end
  assign strb.rdCtx = ctxId;
endmodule

// File: rtl/mclut_dp.sv
module mclut_dp
  import mclut_pkg::*;
#(
  parameter bit PIPE_CTX = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic [NEXT-1:0]  extIn,
  output logic             lutOut,
  output logic             regQ,
  output logic [CFG_W-1:0] rdWord,
  output logic [CFG_W-1:0] effWord
);
  cfg_t slotMem [NCTX];
  cfg_t effCfg;
  logic [NCAND-1:0] cand;
  logic [LUT_K-1:0] addr;

  for (genvar s = 0; s < NCTX; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                slotMem[s] <= '0;
      else if (strb.slotWr[s])  slotMem[s] <= cfg_t'(cfgWord);
    end
  end

  assign rdWord = slotMem[strb.rdCtx];

  if (PIPE_CTX) begin : g_staged
    logic [CFG_W-1:0] stageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= '0;
      else       stageQ <= rdWord;
    end
    assign effWord = stageQ;
  end else begin : g_flat
    assign effWord = rdWord;
  end

  assign effCfg = cfg_t'(effWord);
  assign cand   = {extIn, regQ};

  for (genvar i = 0; i < LUT_K; i++) begin : g_route
    assign addr[i] = cand[effCfg.sel[i]];
  end

  assign lutOut = effCfg.truth[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             regQ <= 1'b0;
    else if (effCfg.regEn) regQ <= lutOut;
  end
endmodule

// File: rtl/mclut_cell.sv
module mclut_cell
  import mclut_pkg::*;
#(
  parameter bit PIPE_CTX = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CTX_W-1:0] ctxId,
  input  logic [NEXT-1:0]  extIn,
  input  logic             cfgWe,
  input  logic [CTX_W-1:0] cfgSlot,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             lutOut,
  output logic             regQ
);
  strobe_t          strb;
  logic [CFG_W-1:0] rdWord;
  logic [CFG_W-1:0] effWord;

  mclut_ctl u_ctl (
    .ctxId(ctxId), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .strb(strb)
  );

  mclut_dp #(.PIPE_CTX(PIPE_CTX)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWord(cfgWord), .extIn(extIn),
    .lutOut(lutOut), .regQ(regQ), .rdWord(rdWord), .effWord(effWord)
  );
endmodule

// File: rtl/mclut_chk.sv
module mclut_chk
  import mclut_pkg::*;
#(
  parameter bit PIPE = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             lutOut,
  input logic             regQ,
  input logic [NCTX-1:0]  slotWr,
  input logic [CFG_W-1:0] rdWord,
  input logic [CFG_W-1:0] effWord
);
  logic aliveQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) aliveQ <= 1'b0;
    else       aliveQ <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> regQ == 1'b0);

  // R2
  slot_write_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotWr));

  // R6
  reg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    effWord[CFG_W-1] |=> regQ == $past(lutOut));

  // R6
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !effWord[CFG_W-1] |=> $stable(regQ));

  if (PIPE) begin : g_pipe_chk
    // R5
    staged_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
      aliveQ |-> effWord == $past(rdWord));
  end
endmodule

bind mclut_cell mclut_chk #(.PIPE(PIPE_CTX)) u_chk (
  .clk(clk), .rstN(rstN), .lutOut(lutOut), .regQ(regQ),
  .slotWr(strb.slotWr), .rdWord(rdWord), .effWord(effWord)
);

// File: tb/mclut_cell_test.sv
module mclut_cell_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  ctxId = '0;
  logic [6:0]  extIn = '0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSlot = '0;
  logic [28:0] cfgWord = '0;
  logic        lutP, regP, lutC, regC;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // model state
  logic [28:0] memM [4];
  logic [28:0] pipeM;
  logic        regPM, regCM;

  always #(CLK_PERIOD/2) clk = ~clk;

  mclut_cell #(.PIPE_CTX(1'b1)) uut (
    .clk(clk), .rstN(rstN), .ctxId(ctxId), .extIn(extIn), .cfgWe(cfgWe),
    .cfgSlot(cfgSlot), .cfgWord(cfgWord), .lutOut(lutP), .regQ(regP)
  );

  mclut_cell #(.PIPE_CTX(1'b0)) uutFlat (
    .clk(clk), .rstN(rstN), .ctxId(ctxId), .extIn(extIn), .cfgWe(cfgWe),
    .cfgSlot(cfgSlot), .cfgWord(cfgWord), .lutOut(lutC), .regQ(regC)
  );

  function automatic logic [28:0] mkWord(input logic en, input int s3, input int s2,
                                         input int s1, input int s0, input logic [15:0] tt);
    return {en, 3'(s3), 3'(s2), 3'(s1), 3'(s0), tt};
  endfunction

  function automatic logic evalLut(input logic [28:0] w, input logic [6:0] ext, input logic rq);
    logic [7:0] cand;
    logic [3:0] a;
    cand = {ext, rq};
    for (int i = 0; i < 4; i++) a[i] = cand[w[16 + 3*i +: 3]];
    return w[a];
  endfunction

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // inputs already driven at the falling edge; check, then advance model over the edge
  task automatic cycleStep(input string tag);
    logic [28:0] wC, wP;
    logic eC, eP;
    #1;
    wC = memM[ctxId];
    wP = pipeM;
    eC = evalLut(wC, extIn, regCM);
    eP = evalLut(wP, extIn, regPM);
    check(tag, "flat lutOut", lutC, eC);
    check(tag, "staged lutOut", lutP, eP);
    check(tag, "flat regQ", regC, regCM);
    check(tag, "staged regQ", regP, regPM);
    @(posedge clk);
    if (wC[28]) regCM = eC;
    if (wP[28]) regPM = eP;
    pipeM = memM[ctxId];
    if (cfgWe) memM[cfgSlot] = cfgWord;
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] c, input logic [6:0] e, input logic we,
                       input logic [1:0] s, input logic [28:0] w);
    ctxId = c; extIn = e; cfgWe = we; cfgSlot = s; cfgWord = w;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [28:0] wAnd, wXor, wCarry, wOr;
    void'($urandom(32'd20240517));
    for (int s = 0; s < 4; s++) memM[s] = '0;
    pipeM = '0; regPM = 1'b0; regCM = 1'b0;

    // R1: reset state with busy inputs
    ctxId = 2'd3; extIn = 7'h7F;
    repeat (2) @(negedge clk);
    check("R1", "flat lutOut in reset", lutC, 1'b0);
    check("R1", "staged regQ in reset", regP, 1'b0);
    rstN = 1'b1;
    for (int c = 0; c < 4; c++) begin
      drive(2'(c), 7'($urandom), 1'b0, 2'd0, '0);
      cycleStep("R1");
    end

    wAnd   = mkWord(1'b1, 4, 3, 2, 1, 16'h8000);   // AND of extIn[3:0], register loads
    wXor   = mkWord(1'b0, 4, 3, 2, 1, 16'h6996);   // parity, register holds
    wCarry = mkWord(1'b0, 1, 1, 1, 0, 16'h4002);   // regQ xor extIn[0], register holds
    wOr    = mkWord(1'b1, 7, 6, 5, 0, 16'hFFFE);   // OR of regQ and extIn[6:4]

    // R2: load every slot, including the active one
    drive(2'd0, 7'h0F, 1'b1, 2'd0, wAnd);  cycleStep("R2");
    drive(2'd0, 7'h0F, 1'b1, 2'd1, wXor);  cycleStep("R4");
    drive(2'd0, 7'h0F, 1'b1, 2'd2, wCarry); cycleStep("R2");
    drive(2'd0, 7'h0E, 1'b1, 2'd3, wOr);   cycleStep("R6");

    // R7: rewrite non-active slots while context 1 runs
    for (int k = 0; k < 6; k++) begin
      drive(2'd1, 7'($urandom), 1'b1, (k % 2) ? 2'd0 : 2'd3, (k % 2) ? wAnd : wOr);
      cycleStep("R7");
    end

    // R5 / R4: context switch each cycle
    for (int k = 0; k < 12; k++) begin
      drive(2'(k), 7'($urandom), 1'b0, 2'd0, '0);
      cycleStep((k % 2) ? "R5" : "R4");
    end

    // R8: compute in ctx0, hold through ctx1, consume in ctx2
    drive(2'd0, 7'h0F, 1'b0, 2'd0, '0); cycleStep("R8");
    drive(2'd0, 7'h0F, 1'b0, 2'd0, '0); cycleStep("R8");
    drive(2'd1, 7'h00, 1'b0, 2'd0, '0); cycleStep("R8");
    drive(2'd1, 7'h05, 1'b0, 2'd0, '0); cycleStep("R8");
    drive(2'd2, 7'h00, 1'b0, 2'd0, '0); cycleStep("R8");
    drive(2'd2, 7'h01, 1'b0, 2'd0, '0); cycleStep("R8");
    drive(2'd2, 7'h00, 1'b0, 2'd0, '0); cycleStep("R8");

    // R6: load zero then hold it
    drive(2'd0, 7'h00, 1'b0, 2'd0, '0); cycleStep("R6");
    drive(2'd0, 7'h00, 1'b0, 2'd0, '0); cycleStep("R6");
    drive(2'd1, 7'h7F, 1'b0, 2'd0, '0); cycleStep("R6");
    drive(2'd1, 7'h7F, 1'b0, 2'd0, '0); cycleStep("R6");

    // R3: random contexts, inputs and occasional writes of random words
    for (int k = 0; k < 400; k++) begin
      drive(2'($urandom), 7'($urandom), ($urandom % 6) == 0, 2'($urandom), 29'($urandom));
      cycleStep("R3");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule